// File: doc/BRIEF.md
# Two-Level Interrupt Acknowledge Sequencer

This block joins two eight-input interrupt controllers into a sixteen-line system. Lines 0 to 7 belong to the primary controller and lines 8 to 15 to the secondary one. The secondary controller's summary request feeds input 2 of the primary. Each controller keeps a pending-request register and an in-service register. A request line is captured either on its rising edge or as a level, as selected per line. The masks, the vector bases and the nesting option arrive on ports. The per-controller command and rotation logic is not part of this block. Priority is fixed, with index 0 highest.

A processor-side agent issues one command at a time through a request port. The command is an acknowledge, a poll of either controller, a combined status poll, a register read, a read-select reset or a specific end-of-service. An acknowledge resolves the cascade and returns an 8-bit vector. When nothing qualifies it substitutes the spurious index 7 at whichever level came up empty. Every command answers after the same number of cycles, with a one-cycle response strobe.

The sequencer has four states.
- `S_IDLE` accepts a command.
- `S_FIRST` acts on the primary controller, or on the target of the command.
- `S_SECOND` resolves the secondary controller when the primary chose input 2.
- `S_RESP` presents the result.

The transitions are:
- IDLE to FIRST on an accepted request.
- FIRST to SECOND and SECOND to RESP unconditionally.
- RESP back to IDLE.

Top module: `cas_ack_seq`

## Requirements
- R1: After reset both controllers have no pending or in-service bits, the read-select points at the pending register, `resp_valid` is 0 and `int_out` is 0.
- R2: An edge-mode line sets its pending bit once per rising edge; holding it high does not set it again. A level-mode line (`trig_lvl` bit 1) makes the pending bit follow the line.
- R3: While the secondary controller has a qualifying request and the sequencer is in IDLE or RESP, primary pending bit 2 is set on the next clock edge. Forwarding pauses in FIRST and SECOND.
- R4: An acknowledge with a primary winner other than input 2 returns `{base_m[7:3], index}`. It sets that in-service bit and clears the pending bit only for an edge-mode line.
- R5: An acknowledge with primary winner 2 marks primary input 2 in service, acknowledges the secondary winner and returns `{base_s[7:3], index}`.
- R6: If the primary winner is 2 but the secondary has no winner at acknowledge time, the vector is `{base_s[7:3], 3'd7}`.
- R7: If the primary has no winner at acknowledge, the vector is `{base_m[7:3], 3'd7}` and no state changes.
- R8: A primary poll (op 1) returns the winning index and clears its pending and in-service bits. With no winner it returns 8'h07.
- R9: A secondary poll (op 2) returns the winning index and clears its bits, together with primary pending and in-service bit 2. With no winner it returns 8'h07 and leaves the primary untouched.
- R10: A status poll (op 3) polls the primary. If the result is 2, it polls the secondary and returns its result plus 8. It then sets the primary read-select, so that a primary read (op 4) returns the in-service register instead of the pending register until op 6 clears the select. A secondary read (op 5) returns the secondary pending register.
- R11: With `nested_m` high, primary in-service bit 2 does not block a new input-2 request. With it low, it does.
- R12: Op codes are: 0 acknowledge, 1 primary poll, 2 secondary poll, 3 status, 4 primary read, 5 secondary read, 6 read-select clear, 7 end-of-service for line `req_line`. A request is taken only in IDLE. `resp_valid` rises exactly three clock edges after acceptance and lasts one cycle.
- R13: The winner is the lowest unmasked pending index, and only when it is lower than the lowest in-service index. Op 7 clears the in-service bit of the named line.
- R14: `int_out` is high exactly when the primary controller has a winner. It is re-evaluated from the state left by each command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 16 | Request lines; line 2 is unused (cascade input) |
| trig_lvl | input | 16 | Per-line level mode (1) or edge mode (0) |
| imr_m | input | 8 | Primary mask, 1 blocks the input |
| imr_s | input | 8 | Secondary mask |
| base_m | input | 8 | Primary vector base, bits 7:3 used |
| base_s | input | 8 | Secondary vector base, bits 7:3 used |
| nested_m | input | 1 | Primary ignores in-service bit 2 for priority |
| req_valid | input | 1 | Command request |
| req_op | input | 3 | Command code (R12) |
| req_line | input | 4 | Line for end-of-service |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_data | output | 8 | Vector, poll result or register value |
| int_out | output | 1 | Interrupt request to the processor |

## Verification
A line change drives a pending bit after one clock edge. A secondary line reaches primary bit 2, and therefore `int_out`, one edge later. The bench therefore waits two falling edges after changing lines before it issues a command. A command response is due on the third rising edge after acceptance, so the bench samples `resp_data` on the third falling edge. A latency test checks that the strobe is absent on the falling edges before and after that one, while the request is still held high. All sampling is on falling edges, half a period away from the edge that updates the state.

// File: rtl/cas_pkg.sv
package cas_pkg;
    localparam int CTL_W   = 8;
    localparam int IDX_W   = $clog2(CTL_W);
    localparam int LINES   = 2 * CTL_W;
    localparam int LINE_W  = $clog2(LINES);
    localparam int CASC_IN = 2;
    localparam int SPUR_IN = CTL_W - 1;
    localparam int VEC_W   = 8;
    localparam int OP_W    = 3;

    typedef enum logic [OP_W-1:0] {
        OP_ACK     = 3'd0,
        OP_POLL_M  = 3'd1,
        OP_POLL_S  = 3'd2,
        OP_STATUS  = 3'd3,
        OP_RD_M    = 3'd4,
        OP_RD_S    = 3'd5,
        OP_CLR_SEL = 3'd6,
        OP_EOI     = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_FIRST  = 2'd1,
        S_SECOND = 2'd2,
        S_RESP   = 2'd3
    } seq_e;
endpackage

// File: rtl/cas_req_bank.sv
module cas_req_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lines,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] casc_set,
    input  logic [W-1:0] set_isr,
    input  logic [W-1:0] clr_irr,
    input  logic [W-1:0] clr_isr,
    output logic [W-1:0] irr,
    output logic [W-1:0] isr
);
    logic [W-1:0] last_q;
    logic [W-1:0] irr_n;
    logic [W-1:0] isr_n;

    always_comb begin
        for (int i = 0; i < W; i++) begin
            if (lvl[i]) begin
                irr_n[i] = lines[i];
            end else begin
                irr_n[i] = irr[i] | (lines[i] & ~last_q[i]);
            end
        end
        irr_n = (irr_n | casc_set) & ~clr_irr;
        isr_n = (isr | set_isr) & ~clr_isr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= '0;
            irr    <= '0;
            isr    <= '0;
        end else begin
            last_q <= lines;
            irr    <= irr_n;
            isr    <= isr_n;
        end
    end

    // R13
    isr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_isr != '0) |=> ((isr & $past(clr_isr)) == '0))
        else $error("in-service bit survived a clear");
endmodule

// File: rtl/cas_prio.sv
module cas_prio #(
    parameter int W  = 8,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  irr,
    input  logic [W-1:0]  imr,
    input  logic [W-1:0]  isr,
    input  logic [W-1:0]  ign,
    output logic          has_win,
    output logic [IW-1:0] win_idx
);
    logic [W-1:0]  req;
    logic [W-1:0]  svc;
    logic [IW-1:0] svc_idx;

    function automatic logic [IW-1:0] low_idx(input logic [W-1:0] v);
        logic [IW-1:0] r;
        r = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (v[i]) r = IW'(i);
        end
        return r;
    endfunction

    always_comb begin
        req     = irr & ~imr;
        svc     = isr & ~ign;
        win_idx = low_idx(req);
        svc_idx = low_idx(svc);
        has_win = (req != '0) && ((svc == '0) || (win_idx < svc_idx));
    end
endmodule

// File: rtl/cas_ack_seq.sv
module cas_ack_seq
    import cas_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINES-1:0]  irq_lines,
    input  logic [LINES-1:0]  trig_lvl,
    input  logic [CTL_W-1:0]  imr_m,
    input  logic [CTL_W-1:0]  imr_s,
    input  logic [VEC_W-1:0]  base_m,
    input  logic [VEC_W-1:0]  base_s,
    input  logic              nested_m,
    input  logic              req_valid,
    input  logic [OP_W-1:0]   req_op,
    input  logic [LINE_W-1:0] req_line,
    output logic              resp_valid,
    output logic [VEC_W-1:0]  resp_data,
    output logic              int_out
);
    localparam logic [CTL_W-1:0] CASC_BIT = CTL_W'(1) << CASC_IN;
    localparam logic [IDX_W-1:0] SPUR_IDX = IDX_W'(SPUR_IN);
    localparam int               HI_W     = VEC_W - IDX_W;

    seq_e state, state_n;
    op_e  op_q;
    logic [LINE_W-1:0] line_q;
    logic [VEC_W-1:0]  data_q;
    logic              second_q;
    logic              rsel_m;
    logic              fwd;

    logic [CTL_W-1:0] irr_a     [2];
    logic [CTL_W-1:0] isr_a     [2];
    logic [CTL_W-1:0] lvl_a     [2];
    logic [CTL_W-1:0] set_isr_a [2];
    logic [CTL_W-1:0] clr_irr_a [2];
    logic [CTL_W-1:0] clr_isr_a [2];
    logic [1:0]       has_a;
    logic [IDX_W-1:0] idx_a     [2];

    assign fwd = has_a[1] && (state == S_IDLE || state == S_RESP);

    for (genvar g = 0; g < 2; g++) begin : g_ctl
        logic [CTL_W-1:0] lines_g, casc_g, ign_g, imr_g;
        if (g == 0) begin : g_pri
            assign lines_g  = irq_lines[CTL_W-1:0] & ~CASC_BIT;
            assign lvl_a[g] = trig_lvl[CTL_W-1:0] & ~CASC_BIT;
            assign casc_g   = fwd ? CASC_BIT : '0;
            assign ign_g    = nested_m ? CASC_BIT : '0;
            assign imr_g    = imr_m;
        end else begin : g_sec
            assign lines_g  = irq_lines[LINES-1:CTL_W];
            assign lvl_a[g] = trig_lvl[LINES-1:CTL_W];
            assign casc_g   = '0;
            assign ign_g    = '0;
            assign imr_g    = imr_s;
        end

        cas_req_bank #(.W(CTL_W)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .lines    (lines_g),
            .lvl      (lvl_a[g]),
            .casc_set (casc_g),
            .set_isr  (set_isr_a[g]),
            .clr_irr  (clr_irr_a[g]),
            .clr_isr  (clr_isr_a[g]),
            .irr      (irr_a[g]),
            .isr      (isr_a[g])
        );

        cas_prio #(.W(CTL_W)) u_prio (
            .irr     (irr_a[g]),
            .imr     (imr_g),
            .isr     (isr_a[g]),
            .ign     (ign_g),
            .has_win (has_a[g]),
            .win_idx (idx_a[g])
        );
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_n;
    end

    always_comb begin
        state_n = state;
        unique case (state)
            S_IDLE:   if (req_valid) state_n = S_FIRST;
            S_FIRST:  state_n = S_SECOND;
            S_SECOND: state_n = S_RESP;
            S_RESP:   state_n = S_IDLE;
        endcase
    end

    // strobes into the two controller banks
    always_comb begin
        for (int g = 0; g < 2; g++) begin
            set_isr_a[g] = '0;
            clr_irr_a[g] = '0;
            clr_isr_a[g] = '0;
        end
        if (state == S_FIRST) begin
            unique case (op_q)
                OP_ACK: if (has_a[0]) begin
                    set_isr_a[0][idx_a[0]] = 1'b1;
                    if (!lvl_a[0][idx_a[0]]) clr_irr_a[0][idx_a[0]] = 1'b1;
                end
                OP_POLL_M, OP_STATUS: if (has_a[0]) begin
                    clr_irr_a[0][idx_a[0]] = 1'b1;
                    clr_isr_a[0][idx_a[0]] = 1'b1;
                end
                OP_POLL_S: if (has_a[1]) begin
                    clr_irr_a[1][idx_a[1]] = 1'b1;
                    clr_isr_a[1][idx_a[1]] = 1'b1;
                    clr_irr_a[0][CASC_IN]  = 1'b1;
                    clr_isr_a[0][CASC_IN]  = 1'b1;
                end
                OP_EOI: clr_isr_a[line_q[LINE_W-1]][line_q[IDX_W-1:0]] = 1'b1;
                default: ;
            endcase
        end else if (state == S_SECOND && second_q) begin
            unique case (op_q)
                OP_ACK: if (has_a[1]) begin
                    set_isr_a[1][idx_a[1]] = 1'b1;
                    if (!lvl_a[1][idx_a[1]]) clr_irr_a[1][idx_a[1]] = 1'b1;
                end
                OP_STATUS: if (has_a[1]) begin
                    clr_irr_a[1][idx_a[1]] = 1'b1;
                    clr_isr_a[1][idx_a[1]] = 1'b1;
                    clr_irr_a[0][CASC_IN]  = 1'b1;
                    clr_isr_a[0][CASC_IN]  = 1'b1;
                end
                default: ;
            endcase
        end
    end

    // command datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q     <= OP_ACK;
            line_q   <= '0;
            data_q   <= '0;
            second_q <= 1'b0;
            rsel_m   <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: if (req_valid) begin
                    op_q   <= op_e'(req_op);
                    line_q <= req_line;
                end
                S_FIRST: begin
                    second_q <= (op_q == OP_ACK || op_q == OP_STATUS)
                                && has_a[0] && (idx_a[0] == IDX_W'(CASC_IN));
                    unique case (op_q)
                        OP_ACK:
                            data_q <= {base_m[VEC_W-1:IDX_W],
                                       has_a[0] ? idx_a[0] : SPUR_IDX};
                        OP_POLL_M, OP_STATUS:
                            data_q <= {HI_W'(0), has_a[0] ? idx_a[0] : SPUR_IDX};
                        OP_POLL_S:
                            data_q <= {HI_W'(0), has_a[1] ? idx_a[1] : SPUR_IDX};
                        OP_RD_M:
                            data_q <= rsel_m ? isr_a[0] : irr_a[0];
                        OP_RD_S:
                            data_q <= irr_a[1];
                        OP_CLR_SEL: begin
                            data_q <= '0;
                            rsel_m <= 1'b0;
                        end
                        OP_EOI:
                            data_q <= '0;
                    endcase
                end
                S_SECOND: begin
                    if (second_q && op_q == OP_ACK) begin
                        data_q <= {base_s[VEC_W-1:IDX_W],
                                   has_a[1] ? idx_a[1] : SPUR_IDX};
                    end
                    if (second_q && op_q == OP_STATUS) begin
                        data_q <= VEC_W'(has_a[1] ? idx_a[1] : SPUR_IDX)
                                  + VEC_W'(CTL_W);
                    end
                    if (op_q == OP_STATUS) rsel_m <= 1'b1;
                end
                S_RESP: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        resp_valid = (state == S_RESP);
        resp_data  = data_q;
        int_out    = has_a[0];
    end

    // R12
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && req_valid) |=> ##2 resp_valid)
        else $error("response not on the third edge");

    // R12
    resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid)
        else $error("response strobe longer than one cycle");

    // R3
    cascade_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (has_a[1] && state == S_IDLE) |=> irr_a[0][CASC_IN])
        else $error("secondary request not forwarded");

    // R7
    spur_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FIRST && op_q == OP_ACK && !has_a[0])
        |=> (resp_data[IDX_W-1:0] == SPUR_IDX))
        else $error("missing spurious vector");

    // R10
    rsel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SECOND && op_q == OP_STATUS) |=> rsel_m)
        else $error("status read did not set read-select");

    // R14
    int_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> ((irr_a[0] & ~imr_m) != '0))
        else $error("interrupt without unmasked request");
endmodule

// File: tb/test_cas_ack_seq.sv
module test_cas_ack_seq;
    localparam int CLK_PERIOD = 10;
    localparam int NSTEP = 29;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] irq_lines, trig_lvl;
    logic [7:0]  imr_m, imr_s, base_m, base_s;
    logic        nested_m, req_valid;
    logic [2:0]  req_op;
    logic [3:0]  req_line;
    logic        resp_valid, int_out;
    logic [7:0]  resp_data;
    int total = 0;
    int bad = 0;
    bit finished = 0;

    cas_ack_seq i_cas_ack_seq (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .trig_lvl(trig_lvl),
        .imr_m(imr_m), .imr_s(imr_s), .base_m(base_m), .base_s(base_s),
        .nested_m(nested_m), .req_valid(req_valid), .req_op(req_op),
        .req_line(req_line), .resp_valid(resp_valid), .resp_data(resp_data),
        .int_out(int_out)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // step: {lines[34:19], op[18:16], line[15:12], expected[11:4], req[3:0]}
    localparam logic [34:0] STEPS [NSTEP] = '{
        {16'h0000, 3'd0, 4'd0,  8'h27, 4'd7},  // R7 nothing pending
        {16'h0008, 3'd0, 4'd0,  8'h23, 4'd4},  // R4 line 3
        {16'h0008, 3'd4, 4'd0,  8'h00, 4'd2},  // R2 held edge line not re-captured
        {16'h0000, 3'd7, 4'd3,  8'h00, 4'd13}, // R13 eos line 3
        {16'h0022, 3'd0, 4'd0,  8'h21, 4'd13}, // R13 lowest index wins
        {16'h0022, 3'd0, 4'd0,  8'h27, 4'd13}, // R13 in-service blocks lower priority
        {16'h0022, 3'd7, 4'd1,  8'h00, 4'd13},
        {16'h0022, 3'd0, 4'd0,  8'h25, 4'd4},
        {16'h0022, 3'd7, 4'd5,  8'h00, 4'd13},
        {16'h0400, 3'd0, 4'd0,  8'h72, 4'd5},  // R5 secondary index 2
        {16'h0400, 3'd4, 4'd0,  8'h00, 4'd14}, // R14 no forward left over
        {16'h0400, 3'd5, 4'd0,  8'h00, 4'd5},
        {16'h0400, 3'd7, 4'd10, 8'h00, 4'd13},
        {16'h0400, 3'd7, 4'd2,  8'h00, 4'd13},
        {16'h0010, 3'd1, 4'd0,  8'h04, 4'd8},  // R8 primary poll
        {16'h0010, 3'd1, 4'd0,  8'h07, 4'd8},  // R8 empty primary poll
        {16'h0000, 3'd2, 4'd0,  8'h07, 4'd9},  // R9 empty secondary poll
        {16'h4000, 3'd4, 4'd0,  8'h04, 4'd3},  // R3 forwarded to primary bit 2
        {16'h4000, 3'd2, 4'd0,  8'h06, 4'd9},  // R9 secondary poll
        {16'h4000, 3'd4, 4'd0,  8'h00, 4'd9},  // R9 primary bit 2 cleared
        {16'h4000, 3'd5, 4'd0,  8'h00, 4'd9},
        {16'h2000, 3'd3, 4'd0,  8'h0D, 4'd10}, // R10 status through cascade
        {16'h2001, 3'd0, 4'd0,  8'h20, 4'd4},
        {16'h2001, 3'd4, 4'd0,  8'h01, 4'd10}, // R10 read-select gives in-service
        {16'h2001, 3'd6, 4'd0,  8'h00, 4'd10},
        {16'h2001, 3'd4, 4'd0,  8'h00, 4'd10}, // R10 back to pending register
        {16'h2001, 3'd7, 4'd0,  8'h00, 4'd13},
        {16'h2001, 3'd3, 4'd0,  8'h07, 4'd10}, // R10 empty status
        {16'h2001, 3'd5, 4'd0,  8'h00, 4'd10}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; irq_lines = '0; trig_lvl = '0; imr_m = '0; imr_s = '0;
        nested_m = 1'b0; req_valid = 1'b0; req_op = '0; req_line = '0;
        wait_n(3);
        rst_n = 1'b1;
    endtask

    // drive at a falling edge, response due on the third falling edge
    task automatic do_op(input logic [2:0] op, input logic [3:0] ln,
                         input logic [7:0] exp, input string tag);
        req_valid = 1'b1; req_op = op; req_line = ln;
        @(negedge clk);
        req_valid = 1'b0;
        wait_n(2);
        chk(tag, {7'd0, resp_valid, resp_data}, {7'd0, 1'b1, exp});
        @(negedge clk);
    endtask

    task automatic set_lines(input logic [15:0] v);
        irq_lines = v;
        wait_n(2);
    endtask

    initial begin
        base_m = 8'h20; base_s = 8'h70;
        do_reset();
        // R1 reset state
        chk("R1 resp_valid", {15'd0, resp_valid}, 16'd0);
        chk("R1 int_out", {15'd0, int_out}, 16'd0);
        do_op(3'd4, 4'd0, 8'h00, "R1 primary regs");
        do_op(3'd5, 4'd0, 8'h00, "R1 secondary regs");

        for (int k = 0; k < NSTEP; k++) begin
            set_lines(STEPS[k][34:19]);
            do_op(STEPS[k][18:16], STEPS[k][15:12], STEPS[k][11:4],
                  $sformatf("R%0d step %0d", STEPS[k][3:0], k));
        end

        // R12 fixed latency, requests while busy ignored
        do_reset();
        set_lines(16'h0003);
        req_valid = 1'b1; req_op = 3'd0;
        @(negedge clk);
        req_op = 3'd1;
        chk("R12 no early strobe 1", {15'd0, resp_valid}, 16'd0);
        @(negedge clk);
        chk("R12 no early strobe 2", {15'd0, resp_valid}, 16'd0);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R12 strobe and vector", {7'd0, resp_valid, resp_data}, {7'd0, 1'b1, 8'h20});
        @(negedge clk);
        chk("R12 one-cycle strobe", {15'd0, resp_valid}, 16'd0);
        wait_n(3);
        chk("R12 no second response", {15'd0, resp_valid}, 16'd0);
        do_op(3'd4, 4'd0, 8'h02, "R12 busy poll ignored");

        // R14 interrupt output, R13 masking
        do_reset();
        set_lines(16'h0010);
        chk("R14 int_out raised", {15'd0, int_out}, 16'd1);
        do_op(3'd0, 4'd0, 8'h24, "R4 line 4");
        chk("R14 int_out dropped after ack", {15'd0, int_out}, 16'd0);
        imr_m = 8'h08;
        set_lines(16'h0018);
        chk("R13 masked line no int", {15'd0, int_out}, 16'd0);
        do_op(3'd0, 4'd0, 8'h27, "R13 masked gives spurious");
        imr_m = 8'h00;
        wait_n(1);
        chk("R13 unmasked higher line", {15'd0, int_out}, 16'd1);

        // R2 level mode
        do_reset();
        trig_lvl = 16'h0002;
        set_lines(16'h0002);
        do_op(3'd0, 4'd0, 8'h21, "R4 level ack");
        do_op(3'd4, 4'd0, 8'h02, "R4 level pending kept");
        do_op(3'd7, 4'd1, 8'h00, "R13 eos");
        set_lines(16'h0000);
        do_op(3'd4, 4'd0, 8'h00, "R2 level follows line");

        // R6 secondary empty while primary input 2 wins
        do_reset();
        imr_s = 8'h00;
        set_lines(16'h0100);
        imr_s = 8'h01;
        do_op(3'd0, 4'd0, 8'h77, "R6 secondary spurious");

        // R11 nesting on
        do_reset();
        nested_m = 1'b1;
        wait_n(1);
        set_lines(16'h0200);
        wait_n(1);
        do_op(3'd0, 4'd0, 8'h71, "R5 secondary line 9");
        set_lines(16'h0300);
        wait_n(1);
        chk("R11 nested int_out", {15'd0, int_out}, 16'd1);
        do_op(3'd0, 4'd0, 8'h70, "R11 nested ack");

        // R11 nesting off
        do_reset();
        set_lines(16'h0200);
        wait_n(1);
        do_op(3'd0, 4'd0, 8'h71, "R5 secondary line 9 again");
        set_lines(16'h0300);
        wait_n(1);
        chk("R11 blocked int_out", {15'd0, int_out}, 16'd0);
        do_op(3'd0, 4'd0, 8'h27, "R11 blocked ack");

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule